// File: doc/BRIEF.md
# Eight-Bit Timer with One Compare Channel

This block is an 8-bit up/down timer that advances on a prescaled clock enable chosen from a small set of external tick sources. It has one compare channel. The channel drives one output pin and raises a compare-match flag. The block also keeps an overflow flag. Software programs it through a simple register port. A control register selects the counting waveform, the action taken on the output pin and the tick source.

Four waveforms are available:
- free-running up-count;
- clear-on-compare, where the compare register acts as TOP;
- single-slope PWM;
- dual-slope PWM.

A write-only force bit in the control register fires a compare action on the pin at once. The forced action uses the pin mode written in that same control word. It does not set the flag, and in clear-on-compare mode it does not clear the counter. The force bit has no effect in the PWM waveforms.

Register addresses (2-bit): 0 control, 1 count, 2 compare value, 3 flags.

Control word fields:

| Bit(s) | Field |
|---|---|
| 7 | force strobe |
| 6 | waveform bit 0 |
| 5:4 | pin mode |
| 3 | waveform bit 1 |
| 2:0 | tick select |

The waveform code is {bit 3, bit 6}. Flag word: bit 0 is the compare flag and bit 1 is the overflow flag.

Top module: `tmr8_cmp_unit`

## Requirements
- R1: After reset, all of the following are 0: the control, count and compare registers, both flags, the pin and the pin enable.
- R2: Control reads return bits 6:0 as written, and bit 7 (force) always reads 0. The waveform code {bit 3, bit 6} means: 00 free-running, 01 dual-slope PWM, 10 clear-on-compare, 11 single-slope PWM.
- R3: Tick select 000 holds the count. A code k from 1 to 7 advances the count only in cycles where tick source k-1 is high.
- R4: In free-running mode, each tick adds one to the count. A tick at 255 wraps the count to 0 and sets the overflow flag. In clear-on-compare mode, a tick at 255 also sets the overflow flag.
- R5: A tick with count equal to the compare value sets the compare flag in the next cycle, and the count still moves on that tick. Writing 1 to flag bit 0 clears the compare flag, and writing 1 to flag bit 1 clears the overflow flag. If a set and a clear arrive in the same cycle, the set wins.
- R6: In clear-on-compare mode, a tick with count equal to the compare value moves the count to 0 instead of incrementing it.
- R7: In the two non-PWM modes, a match changes the pin according to the pin mode: 00 leaves it released (pin enable 0, pin 0), 01 toggles it, 10 drives it to 0 and 11 drives it to 1.
- R8: A control write with bit 7 set and waveform bit 0 clear applies the R7 action of the pin mode being written, one cycle later. It sets no flag and does not clear or move the count. With waveform bit 0 set (a PWM mode), the force bit changes nothing.
- R9: In single-slope PWM, the count wraps 255 to 0 and sets the overflow flag. With pin mode 10, a match drives the pin to 0 and the wrap drives it to 1. Pin mode 11 inverts both actions. If a match and the wrap fall on the same tick, the wrap action wins. Pin modes 00 and 01 release the pin.
- R10: In dual-slope PWM, the count rises to 255 and then falls to 0, reversing at each end. The tick that turns the count at 0 sets the overflow flag. With pin mode 10, a match while rising drives the pin to 0 and a match while falling drives it to 1. Pin mode 11 inverts both actions.
- R11: A count write takes effect in the next cycle and cancels that cycle's tick, so no match, wrap or flag comes from it. A compare write takes effect in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_tick | input | 7 | External prescaler enables, one per source |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 8 | Read data (combinational) |
| oc_pin | output | 1 | Compare output pin level |
| oc_oe | output | 1 | Pin is driven by the compare unit |
| cmp_irq | output | 1 | Compare-match flag |
| ovf_irq | output | 1 | Overflow flag |

## Verification
Most internal faults show up at the ports within one prescaled tick:
- A wrong count or direction appears on the count read at once. It also moves the next match or wrap by whole ticks, so with divide-by-8 ticks both flags and the pin go out of line eight clocks at a time.
- A wrong pin level stays visible until the next match or wrap that rewrites it.
- A force strobe that leaks into the flag or the counter shows up in the cycle right after the control write.

The bench therefore compares every output and the selected read word against an independent model in every cycle.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;

  typedef enum logic [1:0] {
    WM_NORMAL = 2'b00,
    WM_PHASE  = 2'b01,
    WM_CTC    = 2'b10,
    WM_FAST   = 2'b11
  } wave_mode_e;

  typedef enum logic [1:0] {
    OM_OFF    = 2'b00,
    OM_TOGGLE = 2'b01,
    OM_CLEAR  = 2'b10,
    OM_SET    = 2'b11
  } out_mode_e;

  localparam logic [1:0] A_CTRL  = 2'd0;
  localparam logic [1:0] A_COUNT = 2'd1;
  localparam logic [1:0] A_CMP   = 2'd2;
  localparam logic [1:0] A_FLAGS = 2'd3;

  localparam int B_FORCE = 7;
  localparam int B_WM0   = 6;
  localparam int B_OMH   = 5;
  localparam int B_OML   = 4;
  localparam int B_WM1   = 3;
  localparam int CS_W    = 3;

  function automatic logic mode_is_pwm(wave_mode_e m);
    return (m == WM_PHASE) || (m == WM_FAST);
  endfunction

  // pin level after a non-PWM compare action
  function automatic logic match_level(out_mode_e om, logic cur);
    case (om)
      OM_OFF:    return cur;
      OM_TOGGLE: return ~cur;
      OM_CLEAR:  return 1'b0;
      default:   return 1'b1;
    endcase
  endfunction

  // PWM action: invert selects the "opposite" edge (bottom / falling match)
  function automatic logic pwm_level(out_mode_e om, logic invert);
    logic base;
    base = (om == OM_SET);
    return invert ? ~base : base;
  endfunction

  function automatic logic pin_driven(wave_mode_e m, out_mode_e om);
    if (mode_is_pwm(m)) return om[1];
    return om != OM_OFF;
  endfunction

endpackage

// File: rtl/tmr8_regs.sv
module tmr8_regs
  import tmr8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [W-1:0]     wr_data,
  input  logic [1:0]       rd_addr,
  input  logic [W-1:0]     count_q,
  input  logic             cmp_flag,
  input  logic             ovf_flag,
  output logic [W-1:0]     rd_data,
  output wave_mode_e       mode,
  output out_mode_e        om,
  output logic [CS_W-1:0]  csel,
  output logic [W-1:0]     cmp_val,
  output logic             force_evt,
  output out_mode_e        force_om,
  output logic             cnt_load,
  output logic [W-1:0]     cnt_load_val,
  output logic             clr_cmp,
  output logic             clr_ovf
);

  localparam int CTRL_BITS = 7;

  logic [CTRL_BITS-1:0] ctrl_q;
  wave_mode_e           wr_mode;

  logic ctrl_wr, cmp_wr, flag_wr;

  assign ctrl_wr = wr_en && (wr_addr == A_CTRL);
  assign cmp_wr  = wr_en && (wr_addr == A_CMP);
  assign flag_wr = wr_en && (wr_addr == A_FLAGS);

  assign cnt_load     = wr_en && (wr_addr == A_COUNT);
  assign cnt_load_val = wr_data;
  assign clr_cmp      = flag_wr && wr_data[0];
  assign clr_ovf      = flag_wr && wr_data[1];

  assign wr_mode   = wave_mode_e'({wr_data[B_WM1], wr_data[B_WM0]});
  assign force_om  = out_mode_e'(wr_data[B_OMH:B_OML]);
  assign force_evt = ctrl_wr && wr_data[B_FORCE] && !mode_is_pwm(wr_mode);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      cmp_val <= '0;
    end else begin
      if (ctrl_wr) ctrl_q  <= wr_data[CTRL_BITS-1:0];
      if (cmp_wr)  cmp_val <= wr_data;
    end
  end

  assign mode = wave_mode_e'({ctrl_q[B_WM1], ctrl_q[B_WM0]});
  assign om   = out_mode_e'(ctrl_q[B_OMH:B_OML]);
  assign csel = ctrl_q[CS_W-1:0];

  always_comb begin
    case (rd_addr)
      A_CTRL:  rd_data = {{(W-CTRL_BITS){1'b0}}, ctrl_q};
      A_COUNT: rd_data = count_q;
      A_CMP:   rd_data = cmp_val;
      default: rd_data = {{(W-2){1'b0}}, ovf_flag, cmp_flag};
    endcase
  end

endmodule

// File: rtl/tmr8_counter.sv
module tmr8_counter
  import tmr8_pkg::*;
#(
  parameter int W    = 8,
  parameter int NSRC = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  src_tick,
  input  logic [CS_W-1:0]  csel,
  input  wave_mode_e       mode,
  input  logic [W-1:0]     cmp_val,
  input  logic             cnt_load,
  input  logic [W-1:0]     cnt_load_val,
  output logic [W-1:0]     count_q,
  output logic             tick,
  output logic             match_evt,
  output logic             falling,
  output logic             wrap_evt,
  output logic             ovf_evt
);

  localparam logic [W-1:0] MAXV = {W{1'b1}};

  logic [NSRC-1:0] src_hit;
  logic            at_max, at_zero, down_q;

  for (genvar k = 1; k <= NSRC; k++) begin : g_src
    assign src_hit[k-1] = (csel == CS_W'(k)) && src_tick[k-1];
  end

  // a count write cancels the tick of its cycle
  assign tick      = (|src_hit) && !cnt_load;
  assign at_max    = (count_q == MAXV);
  assign at_zero   = (count_q == '0);
  assign match_evt = tick && (count_q == cmp_val);
  assign falling   = down_q;
  assign wrap_evt  = tick && at_max && (mode != WM_PHASE);
  assign ovf_evt   = wrap_evt || (tick && (mode == WM_PHASE) && down_q && at_zero);

  function automatic logic [W-1:0] step_count(wave_mode_e m, logic [W-1:0] c,
                                              logic [W-1:0] cmp, logic down);
    case (m)
      WM_CTC:   return (c == cmp) ? '0 : c + 1'b1;
      WM_PHASE: begin
        if (down) return (c == '0) ? W'(1) : c - 1'b1;
        return (c == MAXV) ? MAXV - 1'b1 : c + 1'b1;
      end
      default:  return c + 1'b1;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (cnt_load) begin
      count_q <= cnt_load_val;
    end else if (tick) begin
      count_q <= step_count(mode, count_q, cmp_val, down_q);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || mode != WM_PHASE) begin
      down_q <= 1'b0;
    end else if (tick) begin
      if (!down_q && at_max)      down_q <= 1'b1;
      else if (down_q && at_zero) down_q <= 1'b0;
    end
  end

endmodule

// File: rtl/tmr8_wavegen.sv
module tmr8_wavegen
  import tmr8_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  wave_mode_e mode,
  input  out_mode_e  om,
  input  logic       match_evt,
  input  logic       falling,
  input  logic       wrap_evt,
  input  logic       force_evt,
  input  out_mode_e  force_om,
  output logic       oc_pin,
  output logic       oc_oe
);

  logic level_q, level_d;

  always_comb begin
    level_d = level_q;
    if (force_evt) begin
      level_d = match_level(force_om, level_q);
    end else if (!mode_is_pwm(mode)) begin
      if (match_evt) level_d = match_level(om, level_q);
    end else if (om[1]) begin
      if (mode == WM_FAST) begin
        if (wrap_evt)       level_d = pwm_level(om, 1'b1);
        else if (match_evt) level_d = pwm_level(om, 1'b0);
      end else if (match_evt) begin
        level_d = pwm_level(om, falling);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) level_q <= 1'b0;
    else        level_q <= level_d;
  end

  assign oc_oe  = pin_driven(mode, om);
  assign oc_pin = oc_oe && level_q;

endmodule

// File: rtl/tmr8_flags.sv
module tmr8_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic match_evt,
  input  logic ovf_evt,
  input  logic clr_cmp,
  input  logic clr_ovf,
  output logic cmp_flag,
  output logic ovf_flag
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_flag <= 1'b0;
      ovf_flag <= 1'b0;
    end else begin
      if (match_evt)    cmp_flag <= 1'b1;
      else if (clr_cmp) cmp_flag <= 1'b0;
      if (ovf_evt)      ovf_flag <= 1'b1;
      else if (clr_ovf) ovf_flag <= 1'b0;
    end
  end

endmodule

// File: rtl/tmr8_cmp_unit.sv
module tmr8_cmp_unit
  import tmr8_pkg::*;
#(
  parameter int W    = 8,
  parameter int NSRC = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_tick,
  input  logic            wr_en,
  input  logic [1:0]      wr_addr,
  input  logic [W-1:0]    wr_data,
  input  logic [1:0]      rd_addr,
  output logic [W-1:0]    rd_data,
  output logic            oc_pin,
  output logic            oc_oe,
  output logic            cmp_irq,
  output logic            ovf_irq
);

  wave_mode_e      mode;
  out_mode_e       om, force_om;
  logic [CS_W-1:0] csel;
  logic [W-1:0]    cmp_val, count_q, cnt_load_val;
  logic            force_evt, cnt_load, clr_cmp, clr_ovf;
  logic            tick, match_evt, falling, wrap_evt, ovf_evt;

  tmr8_regs #(.W(W)) u_regs (
    .clk, .rst_n, .wr_en, .wr_addr, .wr_data, .rd_addr,
    .count_q, .cmp_flag(cmp_irq), .ovf_flag(ovf_irq),
    .rd_data, .mode, .om, .csel, .cmp_val, .force_evt, .force_om,
    .cnt_load, .cnt_load_val, .clr_cmp, .clr_ovf
  );

  tmr8_counter #(.W(W), .NSRC(NSRC)) u_cnt (
    .clk, .rst_n, .src_tick, .csel, .mode, .cmp_val,
    .cnt_load, .cnt_load_val, .count_q, .tick, .match_evt,
    .falling, .wrap_evt, .ovf_evt
  );

  tmr8_wavegen u_wave (
    .clk, .rst_n, .mode, .om, .match_evt, .falling, .wrap_evt,
    .force_evt, .force_om, .oc_pin, .oc_oe
  );

  tmr8_flags u_flags (
    .clk, .rst_n, .match_evt, .ovf_evt, .clr_cmp, .clr_ovf,
    .cmp_flag(cmp_irq), .ovf_flag(ovf_irq)
  );

endmodule

// File: rtl/tmr8_cmp_checker.sv
module tmr8_cmp_checker
  import tmr8_pkg::*;
#(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         tick,
  input logic         cnt_load,
  input logic         match_evt,
  input logic         force_evt,
  input wave_mode_e   mode,
  input logic [W-1:0] count_q,
  input logic [W-1:0] cmp_val,
  input logic         cmp_flag,
  input logic         ovf_flag,
  input logic [1:0]   rd_addr,
  input logic [W-1:0] rd_data,
  input logic         oc_oe,
  input logic         oc_pin
);

  localparam logic [W-1:0] MAXV = {W{1'b1}};

  assert_force_reads_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == A_CTRL) |-> !rd_data[7]);

  assert_hold_without_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !cnt_load) |=> (count_q == $past(count_q)));

  assert_normal_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && mode == WM_NORMAL && count_q == MAXV) |=> (count_q == '0 && ovf_flag));

  assert_match_sets_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    match_evt |=> cmp_flag);

  assert_ctc_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && mode == WM_CTC && count_q == cmp_val) |=> (count_q == '0));

  assert_pin_released_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !oc_oe |-> !oc_pin);

  assert_force_no_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (force_evt && !match_evt && !cmp_flag) |=> !cmp_flag);

  assert_force_keeps_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (force_evt && !tick) |=> (count_q == $past(count_q)));

  assert_fast_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && mode == WM_FAST && count_q == MAXV) |=> (count_q == '0 && ovf_flag));

  assert_phase_turn_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && mode == WM_PHASE && count_q == MAXV) |=> (count_q == MAXV - 1'b1));

endmodule

bind tmr8_cmp_unit tmr8_cmp_checker #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .cnt_load(cnt_load),
  .match_evt(match_evt), .force_evt(force_evt), .mode(mode),
  .count_q(count_q), .cmp_val(cmp_val), .cmp_flag(cmp_irq),
  .ovf_flag(ovf_irq), .rd_addr(rd_addr), .rd_data(rd_data),
  .oc_oe(oc_oe), .oc_pin(oc_pin)
);

// File: tb/sim_tmr8_cmp_unit.sv
module sim_tmr8_cmp_unit;

  localparam int W = 8, NSRC = 7;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic            rst_n = 1'b0;
  logic [NSRC-1:0] src_tick = '0;
  logic            wr_en = 1'b0;
  logic [1:0]      wr_addr = '0;
  logic [W-1:0]    wr_data = '0;
  logic [1:0]      rd_addr = 2'd1;
  logic [W-1:0]    rd_data;
  logic            oc_pin, oc_oe, cmp_irq, ovf_irq;

  tmr8_cmp_unit #(.W(W), .NSRC(NSRC)) u0 (
    .clk, .rst_n, .src_tick, .wr_en, .wr_addr, .wr_data, .rd_addr,
    .rd_data, .oc_pin, .oc_oe, .cmp_irq, .ovf_irq
  );

  int n_chk = 0, n_err = 0;
  int unsigned bc = 0;

  // reference state
  logic [7:0] m_cnt, m_cmp;
  logic [6:0] m_ctrl;
  logic m_dir, m_lvl, m_cf, m_of;

  function automatic logic act(logic [1:0] o, logic l);
    case (o)
      2'd0: return l;
      2'd1: return ~l;
      2'd2: return 1'b0;
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic [1:0] wcode(logic [6:0] c);
    return {c[3], c[6]};
  endfunction

  function automatic logic [7:0] exp_rd(logic [1:0] a);
    case (a)
      2'd0: return {1'b0, m_ctrl};
      2'd1: return m_cnt;
      2'd2: return m_cmp;
      default: return {6'd0, m_of, m_cf};
    endcase
  endfunction

  function automatic logic exp_oe();
    logic [1:0] o;
    o = m_ctrl[5:4];
    return m_ctrl[6] ? o[1] : (o != 2'd0);
  endfunction

  function automatic string cnt_tag();
    if (m_ctrl[2:0] == 3'd0) return "R3";
    case (wcode(m_ctrl))
      2'd0: return "R4";
      2'd1: return "R10";
      2'd2: return "R6";
      default: return "R9";
    endcase
  endfunction

  function automatic string pin_tag();
    if (!m_ctrl[6]) return "R7";
    return m_ctrl[3] ? "R9" : "R10";
  endfunction

  task automatic check(string tag, logic [7:0] actual, logic [7:0] expected);
    n_chk++;
    if (actual !== expected) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, actual, expected, bc);
    end
  endtask

  task automatic model_reset();
    m_cnt = 0; m_cmp = 0; m_ctrl = 0; m_dir = 0; m_lvl = 0; m_cf = 0; m_of = 0;
  endtask

  task automatic compare_all();
    string t;
    case (rd_addr)
      2'd0: t = "R2";
      2'd1: t = cnt_tag();
      2'd2: t = "R11";
      default: t = "R5";
    endcase
    check(t, rd_data, exp_rd(rd_addr));
    check("R5", {7'd0, cmp_irq}, {7'd0, m_cf});
    check(m_ctrl[6] ? pin_tag() : "R4", {7'd0, ovf_irq}, {7'd0, m_of});
    check(pin_tag(), {7'd0, oc_oe}, {7'd0, exp_oe()});
    check(pin_tag(), {7'd0, oc_pin}, {7'd0, exp_oe() & m_lvl});
  endtask

  // one clock: model next state from driven inputs, edge, then compare
  task automatic cyc();
    logic [1:0] wc, o;
    logic tk, hit, top, ld, frc;
    logic [7:0] n_cnt, n_cmp;
    logic [6:0] n_ctrl;
    logic n_dir, n_lvl, n_cf, n_of;
    int unsigned cs;
    src_tick[0] = 1'b1;
    src_tick[1] = (bc % 8) == 0;
    src_tick[2] = (bc % 64) == 0;
    src_tick[6:3] = 4'($urandom);
    bc++;
    wc = wcode(m_ctrl);
    o  = m_ctrl[5:4];
    cs = m_ctrl[2:0];
    ld = wr_en && wr_addr == 2'd1;
    tk = (cs != 0) && src_tick[cs-1] && !ld;
    hit = tk && (m_cnt == m_cmp);
    top = (m_cnt == 8'hFF);
    n_cnt = m_cnt; n_dir = m_dir; n_lvl = m_lvl; n_ctrl = m_ctrl; n_cmp = m_cmp;
    if (ld) n_cnt = wr_data;
    else if (tk) begin
      if (wc == 2'd1) n_cnt = m_dir ? ((m_cnt == 0) ? 8'd1 : m_cnt - 8'd1)
                                    : (top ? 8'd254 : m_cnt + 8'd1);
      else if (wc == 2'd2 && hit) n_cnt = 8'd0;
      else n_cnt = m_cnt + 8'd1;
    end
    if (wc != 2'd1) n_dir = 1'b0;
    else if (tk && !m_dir && top) n_dir = 1'b1;
    else if (tk && m_dir && m_cnt == 0) n_dir = 1'b0;
    n_cf = hit | (m_cf & !(wr_en && wr_addr == 2'd3 && wr_data[0]));
    n_of = (tk && ((wc != 2'd1 && top) || (wc == 2'd1 && m_dir && m_cnt == 0)))
         | (m_of & !(wr_en && wr_addr == 2'd3 && wr_data[1]));
    frc = wr_en && wr_addr == 2'd0 && wr_data[7] && !wr_data[6];
    if (frc) n_lvl = act(wr_data[5:4], m_lvl);
    else if (!m_ctrl[6]) begin
      if (hit) n_lvl = act(o, m_lvl);
    end else if (o[1]) begin
      if (wc == 2'd3) begin
        if (tk && top) n_lvl = (o == 2'd2);
        else if (hit) n_lvl = (o == 2'd3);
      end else if (hit) n_lvl = (o == 2'd3) ^ m_dir;
    end
    if (wr_en && wr_addr == 2'd0) n_ctrl = wr_data[6:0];
    if (wr_en && wr_addr == 2'd2) n_cmp = wr_data;
    @(posedge clk);
    m_cnt = n_cnt; m_cmp = n_cmp; m_ctrl = n_ctrl; m_dir = n_dir;
    m_lvl = n_lvl; m_cf = n_cf; m_of = n_of;
    #1 wr_en = 1'b0;
    @(negedge clk);
    compare_all();
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    cyc();
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic p;
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check("R1", rd_data, 8'h00);
    check("R1", {6'd0, cmp_irq, ovf_irq}, 8'h00);
    check("R1", {6'd0, oc_oe, oc_pin}, 8'h00);
    compare_all();

    // R2 force bit reads 0; fast PWM so force ignored
    wr(2'd0, 8'hFF);
    rd_addr = 2'd0; cyc();
    check("R2", rd_data, 8'h7F);
    rd_addr = 2'd1;

    // R3 stopped counter
    wr(2'd0, 8'h00); wr(2'd1, 8'd77);
    run(30);
    check("R3", rd_data, 8'd77);

    // R6 CTC with divide-by-8 ticks, toggle pin
    wr(2'd3, 8'h03); wr(2'd2, 8'd3); wr(2'd1, 8'd0);
    wr(2'd0, 8'h1A);
    run(100);
    check("R6", {7'd0, rd_data > 8'd3}, 8'd0);
    check("R5", {7'd0, cmp_irq}, 8'd1);

    // R8 force in normal mode, stopped: toggles, no flag
    wr(2'd0, 8'h10); wr(2'd3, 8'h03);
    p = oc_pin;
    wr(2'd0, 8'h90);
    check("R8", {7'd0, oc_pin}, {7'd0, ~p});
    check("R8", {7'd0, cmp_irq}, 8'd0);
    // R8 force in CTC with count at compare: no clear
    wr(2'd2, 8'd5); wr(2'd1, 8'd5);
    wr(2'd0, 8'h98);
    check("R8", rd_data, 8'd5);
    check("R8", {7'd0, cmp_irq}, 8'd0);
    // R8 force ignored in single-slope PWM
    wr(2'd0, 8'h68);
    p = oc_pin;
    wr(2'd0, 8'hE8);
    check("R8", {7'd0, oc_pin}, {7'd0, p});

    // R11 count write cancels tick
    wr(2'd0, 8'h01);
    wr(2'd1, 8'd200);
    check("R11", rd_data, 8'd200);

    // R9 full single-slope period, R10 full dual-slope period
    wr(2'd2, 8'd100); wr(2'd1, 8'd0); wr(2'd0, 8'h69); run(600);
    wr(2'd1, 8'd0); wr(2'd0, 8'h61); run(600);
    wr(2'd0, 8'h71); run(600);
    // R4 normal wrap, set-on-match
    wr(2'd3, 8'h03); wr(2'd1, 8'd250); wr(2'd0, 8'h31); run(10);
    check("R4", {7'd0, ovf_irq}, 8'd1);

    // constrained random segments
    for (int s = 0; s < 60; s++) begin
      logic [7:0] c;
      c = 8'($urandom) & 8'h7F;
      case ($urandom % 3)
        0: c[2:0] = 3'd1;
        1: c[2:0] = 3'd2;
        default: ;
      endcase
      wr(2'd2, 8'($urandom));
      wr(2'd0, c);
      for (int i = 0; i < 300; i++) begin
        int unsigned r;
        r = $urandom % 100;
        rd_addr = ($urandom % 10 == 0) ? 2'($urandom) : 2'd1;
        if (r == 0) begin
          v = 8'($urandom); wr_en = 1'b1; wr_addr = 2'd1; wr_data = v;
        end else if (r == 1) begin
          wr_en = 1'b1; wr_addr = 2'd3; wr_data = 8'($urandom % 4);
        end else if (r == 2) begin
          wr_en = 1'b1; wr_addr = 2'd0; wr_data = {1'b1, c[6:0]};
        end
        cyc();
      end
    end
    rd_addr = 2'd1;
    summary();
    $finish;
  end

endmodule